// File: doc/BRIEF.md
# Segmented Virtual-to-Physical Address Relocator

This block turns a 16-bit virtual address into a 22-bit physical address. The top three address bits pick one of eight 8 KB segments, and the low thirteen bits are the offset inside that segment. Kernel and user mode each have their own register sets. Within each mode there is one set for instruction references and one for data references. Each segment has a base register and a descriptor register. The descriptor holds an access code, a growth direction and a length in 64-byte blocks.

Software programs the segment registers and two control registers through a simple word-addressed register port. The processor presents each memory reference on the translation port with its virtual address, mode, instruction/data select and direction. In the same cycle the block returns the relocated address, or an abort with the trap vector to take.

Top module: `seg_mmu`

## Requirements
- R1: After reset every segment register and both control registers read as zero, so relocation is off.
- R2: With relocation off (control-0 bit 0 clear), `xl_paddr` equals `xl_vaddr` zero-extended to 22 bits and no abort is raised, whatever the segment registers hold.
- R3: With relocation on, `xl_paddr` is the selected base register times 64 plus the 13-bit offset `xl_vaddr[12:0]`, where the segment is `xl_vaddr[15:13]`.
- R4: When control-3 bit 4 (wide mapping) is clear, the relocated address is cut to its low 18 bits. When the bit is set, all 22 bits are kept.
- R5: Register word address `cfg_addr[6]=0` selects a segment register. Bit 5 selects the mode (1 = user), bit 4 selects base (1) or descriptor (0), bit 3 selects data (1) or instruction (0), and bits 2:0 select the segment. A descriptor keeps only length bits 14:8, direction bit 3 and access bits 2:0; its other bits read as zero.
- R6: In an upward segment (descriptor bit 3 = 0), a reference aborts when its block number `xl_vaddr[12:6]` is greater than the length field. A length of 0 therefore still allows block 0.
- R7: In a downward segment (descriptor bit 3 = 1), a reference aborts when its block number is less than the length field.
- R8: Access code 6 permits reads and writes. Code 2 permits reads and aborts writes. Every other code aborts all references.
- R9: Control-3 bit 0 (user) and bit 2 (kernel) enable separate data registers for that mode. When the bit is clear, data references use the instruction registers.
- R10: Kernel and user register sets are independent: writing one mode's registers does not change the other mode's translation.
- R11: `xl_abort` rises only while `xl_req` is high, in the same cycle as the reference. `xl_vector` reads octal 250 during an abort and zero otherwise.
- R12: Control register 0 sits at word 64 and keeps only bit 0. Control register 3 sits at word 65 and keeps only bits 0, 2 and 4. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register word address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| xl_req | input | 1 | Translation request valid |
| xl_vaddr | input | 16 | Virtual address |
| xl_user | input | 1 | 1 = user mode, 0 = kernel mode |
| xl_dspace | input | 1 | 1 = data reference, 0 = instruction reference |
| xl_write | input | 1 | 1 = write reference |
| xl_paddr | output | 22 | Physical address |
| xl_abort | output | 1 | Reference aborted |
| xl_vector | output | 9 | Trap vector for an abort |

## Verification
The assertions assume that the translation inputs are steady between clock edges. They also assume that the control registers change only through `cfg_wr` writes at the register port, so the state of the relocation and wide-mapping bits follows directly from the last write. The bench meets both assumptions. It changes inputs only on the falling edge, performs every register update as a single-cycle write, and samples the combinational translation a short delay after the inputs settle.

// File: rtl/seg_mmu.sv
module seg_mmu #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 22,
  parameter int NA_W   = 18,
  parameter int SEG_W  = 3,
  parameter int BLK_W  = 7,
  parameter int AC_W   = 3,
  parameter int VEC_W  = 9,
  parameter logic [8:0] TRAP_VEC = 9'o250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [6:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             xl_req,
  input  logic [VA_W-1:0]  xl_vaddr,
  input  logic             xl_user,
  input  logic             xl_dspace,
  input  logic             xl_write,
  output logic [PA_W-1:0]  xl_paddr,
  output logic             xl_abort,
  output logic [VEC_W-1:0] xl_vector
);
  localparam int OFF_W  = VA_W - SEG_W;
  localparam int NSEG   = 1 << SEG_W;
  localparam int IDX_W  = SEG_W + 2;
  localparam int NREG   = 1 << IDX_W;
  localparam int BASE_W = PA_W - 6;

  logic [BASE_W-1:0] base_q [NREG];
  logic [BLK_W-1:0]  len_q  [NREG];
  logic              down_q [NREG];
  logic [AC_W-1:0]   acc_q  [NREG];
  logic              reloc_en;
  logic [2:0]        ctl3_q;
  logic              wide_en;

  assign wide_en = ctl3_q[2];

  logic [IDX_W-1:0] ridx;
  assign ridx = {cfg_addr[5], cfg_addr[3], cfg_addr[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        down_q[i] <= 1'b0;
        acc_q[i]  <= '0;
      end
      reloc_en <= 1'b0;
      ctl3_q   <= '0;
    end else if (cfg_wr) begin
      if (!cfg_addr[6]) begin
        if (cfg_addr[4]) begin
          base_q[ridx] <= cfg_wdata[BASE_W-1:0];
        end else begin
          len_q[ridx]  <= cfg_wdata[8+BLK_W-1:8];
          down_q[ridx] <= cfg_wdata[3];
          acc_q[ridx]  <= cfg_wdata[AC_W-1:0];
        end
      end else if (cfg_addr[5:0] == 6'd0) begin
        reloc_en <= cfg_wdata[0];
      end else if (cfg_addr[5:0] == 6'd1) begin
        ctl3_q <= {cfg_wdata[4], cfg_wdata[2], cfg_wdata[0]};
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (!cfg_addr[6]) begin
      if (cfg_addr[4]) cfg_rdata = base_q[ridx];
      else cfg_rdata = {1'b0, len_q[ridx], 4'b0000, down_q[ridx], acc_q[ridx]};
    end else if (cfg_addr[5:0] == 6'd0) begin
      cfg_rdata = {15'd0, reloc_en};
    end else if (cfg_addr[5:0] == 6'd1) begin
      cfg_rdata = {11'd0, ctl3_q[2], 1'b0, ctl3_q[1], 1'b0, ctl3_q[0]};
    end
  end

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [BLK_W-1:0] blk;
  logic             sep;
  logic [IDX_W-1:0] tidx;
  logic [PA_W-1:0]  full;
  logic [PA_W-1:0]  mapped;
  logic             len_bad;
  logic             acc_bad;

  assign seg  = xl_vaddr[VA_W-1:OFF_W];
  assign off  = xl_vaddr[OFF_W-1:0];
  assign blk  = off[OFF_W-1:6];
  assign sep  = xl_user ? ctl3_q[0] : ctl3_q[1];
  assign tidx = {xl_user, xl_dspace & sep, seg};
  assign full = {base_q[tidx], 6'd0} + {{(PA_W-OFF_W){1'b0}}, off};
  assign mapped = wide_en ? full : {{(PA_W-NA_W){1'b0}}, full[NA_W-1:0]};

  assign len_bad = down_q[tidx] ? (blk < len_q[tidx]) : (blk > len_q[tidx]);

  always_comb begin
    case (acc_q[tidx])
      3'd6:    acc_bad = 1'b0;
      3'd2:    acc_bad = xl_write;
      default: acc_bad = 1'b1;
    endcase
  end

  assign xl_abort  = xl_req & reloc_en & (len_bad | acc_bad);
  assign xl_paddr  = reloc_en ? mapped : {{(PA_W-VA_W){1'b0}}, xl_vaddr};
  assign xl_vector = xl_abort ? TRAP_VEC : '0;

  logic unused_ok;
  assign unused_ok = ^{cfg_wdata[15], cfg_wdata[7:4], NSEG[0]};
endmodule

// File: rtl/seg_mmu_chk.sv
module seg_mmu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [6:0]  cfg_addr,
  input logic [15:0] cfg_wdata,
  input logic        xl_req,
  input logic [15:0] xl_vaddr,
  input logic [21:0] xl_paddr,
  input logic        xl_abort,
  input logic [8:0]  xl_vector,
  input logic        reloc_en,
  input logic        wide_en
);
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reloc_en |-> (xl_paddr == {6'd0, xl_vaddr} && !xl_abort));

  p_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xl_abort |-> xl_vector == 9'o250);

  p_noreq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |-> (!xl_abort && xl_vector == 9'd0));

  p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reloc_en && !wide_en) |-> xl_paddr[21:18] == 4'd0);

  p_ctl0_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 7'd64) |=> reloc_en == $past(cfg_wdata[0]));
endmodule

bind seg_mmu seg_mmu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .xl_req(xl_req), .xl_vaddr(xl_vaddr),
  .xl_paddr(xl_paddr), .xl_abort(xl_abort), .xl_vector(xl_vector),
  .reloc_en(reloc_en), .wide_en(wide_en)
);

// File: tb/seg_mmu_tb.sv
module seg_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        xl_req = 1'b0;
  logic [15:0] xl_vaddr = '0;
  logic        xl_user = 1'b0;
  logic        xl_dspace = 1'b0;
  logic        xl_write = 1'b0;
  logic [21:0] xl_paddr;
  logic        xl_abort;
  logic [8:0]  xl_vector;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_mmu u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xl_req(xl_req),
    .xl_vaddr(xl_vaddr), .xl_user(xl_user), .xl_dspace(xl_dspace),
    .xl_write(xl_write), .xl_paddr(xl_paddr), .xl_abort(xl_abort),
    .xl_vector(xl_vector)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(string req, input logic [6:0] a, input logic [15:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #2 check(req, {16'd0, cfg_rdata}, {16'd0, exp});
  endtask

  task automatic xl(string req, input logic [15:0] va, input logic u, input logic ds,
                    input logic w, input logic [21:0] exp_pa, input logic exp_ab);
    @(negedge clk);
    xl_req = 1'b1; xl_vaddr = va; xl_user = u; xl_dspace = ds; xl_write = w;
    #2;
    check({req, " abort"}, {31'd0, xl_abort}, {31'd0, exp_ab});
    if (!exp_ab) check({req, " paddr"}, {10'd0, xl_paddr}, {10'd0, exp_pa});
    else check({req, " vector"}, {23'd0, xl_vector}, 32'o250);
  endtask

  task automatic t_reset;
    rd("R1 ctl0", 7'd64, 16'h0000);
    rd("R1 ctl3", 7'd65, 16'h0000);
    rd("R1 par", 7'd21, 16'h0000);
    rd("R1 pdr", 7'd40, 16'h0000);
  endtask

  task automatic t_regmap;
    wr(7'd0, 16'hFFFF);
    rd("R5 pdr mask", 7'd0, 16'h7F0F);
    wr(7'd61, 16'h1234);
    rd("R5 user d par", 7'd61, 16'h1234);
    rd("R5 other par", 7'd29, 16'h0000);
    wr(7'd65, 16'hFFFF);
    rd("R12 ctl3 mask", 7'd65, 16'h0015);
    wr(7'd64, 16'hFFFF);
    rd("R12 ctl0 mask", 7'd64, 16'h0001);
    wr(7'd64, 16'h0000);
    wr(7'd65, 16'h0000);
    wr(7'd0, 16'h0000);
  endtask

  task automatic t_passthru;
    xl("R2 passthru", 16'hFFFF, 1'b1, 1'b1, 1'b1, 22'h00FFFF, 1'b0);
    xl("R2 passthru k", 16'o123456, 1'b0, 1'b0, 1'b0, 22'o123456, 1'b0);
  endtask

  task automatic t_reloc;
    wr(7'd17, 16'hFE00);
    wr(7'd1, 16'h7F06);
    wr(7'd65, 16'h0010);
    wr(7'd64, 16'h0001);
    xl("R3 wide", 16'o021234, 1'b0, 1'b0, 1'b0, 22'h3F829C, 1'b0);
    wr(7'd65, 16'h0000);
    xl("R4 narrow", 16'o021234, 1'b0, 1'b0, 1'b0, 22'h03829C, 1'b0);
    wr(7'd65, 16'h0010);
  endtask

  task automatic t_updown;
    wr(7'd18, 16'h0000);
    wr(7'd2, 16'h0306);
    xl("R6 up last ok", 16'h4000 + 16'd192 + 16'd63, 1'b0, 1'b0, 1'b0, 22'd255, 1'b0);
    xl("R6 up over", 16'h4000 + 16'd256, 1'b0, 1'b0, 1'b0, 22'd0, 1'b1);
    wr(7'd2, 16'h0006);
    xl("R6 zero len blk0", 16'h4000 + 16'd10, 1'b0, 1'b0, 1'b0, 22'd10, 1'b0);
    xl("R6 zero len blk1", 16'h4000 + 16'd64, 1'b0, 1'b0, 1'b0, 22'd0, 1'b1);
    wr(7'd2, 16'h030E);
    xl("R7 down below", 16'h4000 + 16'd128, 1'b0, 1'b0, 1'b0, 22'd0, 1'b1);
    xl("R7 down at len", 16'h4000 + 16'd192, 1'b0, 1'b0, 1'b0, 22'd192, 1'b0);
    xl("R7 down top", 16'h5FFE, 1'b0, 1'b0, 1'b0, 22'h1FFE, 1'b0);
  endtask

  task automatic t_access;
    wr(7'd19, 16'h0010);
    wr(7'd3, 16'h7F02);
    xl("R8 ro read", 16'h6004, 1'b0, 1'b0, 1'b0, 22'h0404, 1'b0);
    xl("R8 ro write", 16'h6004, 1'b0, 1'b0, 1'b1, 22'd0, 1'b1);
    wr(7'd3, 16'h7F00);
    xl("R8 nonres read", 16'h6004, 1'b0, 1'b0, 1'b0, 22'd0, 1'b1);
    wr(7'd3, 16'h7F04);
    xl("R8 code4 read", 16'h6004, 1'b0, 1'b0, 1'b0, 22'd0, 1'b1);
    wr(7'd3, 16'h7F06);
    xl("R8 rw write", 16'h6004, 1'b0, 1'b0, 1'b1, 22'h0404, 1'b0);
  endtask

  task automatic t_idsep;
    wr(7'd16, 16'h0100); wr(7'd0, 16'h7F06);
    wr(7'd24, 16'h0200); wr(7'd8, 16'h7F06);
    wr(7'd48, 16'h0300); wr(7'd32, 16'h7F06);
    wr(7'd56, 16'h0400); wr(7'd40, 16'h7F06);
    xl("R9 k nosep d", 16'h0002, 1'b0, 1'b1, 1'b0, 22'h4002, 1'b0);
    wr(7'd65, 16'h0014);
    xl("R9 k sep d", 16'h0002, 1'b0, 1'b1, 1'b0, 22'h8002, 1'b0);
    xl("R9 u nosep d", 16'h0002, 1'b1, 1'b1, 1'b0, 22'hC002, 1'b0);
    wr(7'd65, 16'h0015);
    xl("R9 u sep d", 16'h0002, 1'b1, 1'b1, 1'b0, 22'h10002, 1'b0);
    wr(7'd48, 16'h0700);
    xl("R10 kernel kept", 16'h0002, 1'b0, 1'b0, 1'b0, 22'h4002, 1'b0);
    xl("R10 user moved", 16'h0002, 1'b1, 1'b0, 1'b0, 22'h1C002, 1'b0);
  endtask

  task automatic t_req;
    wr(7'd4, 16'h7F00);
    @(negedge clk);
    xl_req = 1'b0; xl_vaddr = 16'h8000; xl_user = 1'b0; xl_dspace = 1'b0; xl_write = 1'b0;
    #2;
    check("R11 no req abort", {31'd0, xl_abort}, 32'd0);
    check("R11 no req vector", {23'd0, xl_vector}, 32'd0);
    xl("R11 req abort", 16'h8000, 1'b0, 1'b0, 1'b0, 22'd0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthru();
    t_regmap();
    t_reloc();
    t_updown();
    t_access();
    t_idsep();
    t_req();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule